// File: doc/BRIEF.md
# Phase-Accumulator Stepper Pulse Generator

This block turns a signed step-rate word into drive signals for a stepper motor. A fractional accumulator integrates the rate on every enabled clock, and each overflow or underflow out of it asks for one step in the matching direction. A timing sequencer then issues the step while enforcing four programmable intervals, all counted in clock cycles: pulse width, minimum gap between pulses, direction setup before a pulse, and direction hold after a pulse.

Three output encodings are selectable at run time: a step line with a direction line, separate up and down pulse lines, or a two-bit Gray quadrature pair that moves one state per step. A signed step counter and the accumulator's fractional phase together give position feedback with finer than one-step resolution. Deasserting the enable stops motion immediately, with no ramp.

Top module: `step_pulse_gen`

## Requirements
- R1: On every clock with `en` high, the signed `rate` (|rate| below 2^ACC_W) is added to an unsigned ACC_W-bit fraction; an overflow requests one positive step and an underflow one negative step. Once motion has settled, `pos_count` equals floor(S / 2^ACC_W) and `pos_frac` equals S mod 2^ACC_W, where S is the sum of all rates applied since reset.
- R2: Every step pulse stays high for exactly max(step_len,1) clocks (on `out_a` in format 0, on `out_a` or `out_b` in format 1).
- R3: The low time between two consecutive step pulses is at least max(step_space,1) clocks.
- R4: The direction changes only while no pulse is active or just ended, and no sooner than max(dir_hold,1) clocks after the previous pulse ended.
- R5: A step pulse begins no sooner than max(dir_setup,1) clocks after the direction last changed.
- R6: A step request that arrives while an interval is still running is held and issued later; while one request is held, further requests are discarded.
- R7: While `en` is low no new pulse is issued, a held request is dropped, the fraction is frozen and `pos_count` does not change; a pulse already in flight completes its length.
- R8: `fmt` selects the encoding: 0 gives step on `out_a` and direction on `out_b` (1 = positive); 1 pulses `out_a` for positive and `out_b` for negative steps, never both at once; 2 selects quadrature.
- R9: In format 2, {`out_a`,`out_b`} is the Gray code of pos_count[1:0] (0→00, 1→01, 2→11, 3→10), so each step moves exactly one output bit.
- R10: `pos_count` is a 32-bit signed value that changes by +1 or -1, in the step's direction, on the same clock edge at which that step's pulse begins, and at no other time.
- R11: After reset `pos_count` and `pos_frac` are zero, both outputs are low and the direction is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Motion enable |
| rate | input | RATE_W | Signed step rate, in steps per clock scaled by 2^ACC_W |
| fmt | input | 2 | Output encoding select |
| step_len | input | TIME_W | Pulse width in clocks |
| step_space | input | TIME_W | Minimum gap between pulses in clocks |
| dir_setup | input | TIME_W | Direction setup before a pulse in clocks |
| dir_hold | input | TIME_W | Direction hold after a pulse in clocks |
| out_a | output | 1 | Output line A |
| out_b | output | 1 | Output line B |
| pos_count | output | POS_W | Signed step count |
| pos_frac | output | ACC_W | Fractional accumulator phase |

## Verification
The bench builds the block with its default widths: a 16-bit fraction and rate, 8-bit interval counters and a 32-bit count. It sweeps all three encodings against four interval sets and four rate pairs, including reversals, so that the exact floor and modulo of the accumulated rate sum can be predicted arithmetically while every pulse width, gap, setup and hold is measured. Rates up to 2^12 keep requests slower than the worst interval chain, so no step should be lost there. A separate long-pulse run drives requests faster than the pulses can be issued to expose the single held request, and a disable run checks the frozen state.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    FMT_STEP_DIR = 2'd0,
    FMT_UP_DOWN  = 2'd1,
    FMT_QUAD     = 2'd2
  } out_fmt_e;
endpackage

// File: rtl/stg_accum.sv
module stg_accum #(
  parameter int ACC_W  = 16,
  parameter int RATE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [RATE_W-1:0] rate,
  output logic                     req_vld,
  output logic                     req_up,
  output logic [ACC_W-1:0]         frac
);
  localparam int SUM_W = ACC_W + 2;
  localparam int EXT_W = SUM_W - RATE_W;

  logic [SUM_W-1:0] sum;
  logic             carry, borrow;
  logic [ACC_W-1:0] frac_n;
  logic             vld_n, up_n;

  // Fraction plus sign-extended rate; top bit flags a borrow, next a carry.
  always_comb begin
    sum    = {2'b00, frac} + {{EXT_W{rate[RATE_W-1]}}, rate};
    borrow = sum[SUM_W-1];
    carry  = !sum[SUM_W-1] && sum[ACC_W];
    frac_n = frac;
    vld_n  = 1'b0;
    up_n   = 1'b0;
    if (en) begin
      frac_n = sum[ACC_W-1:0];
      vld_n  = carry | borrow;
      up_n   = carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac    <= '0;
      req_vld <= 1'b0;
      req_up  <= 1'b0;
    end else begin
      frac    <= frac_n;
      req_vld <= vld_n;
      req_up  <= up_n;
    end
  end
endmodule

// File: rtl/stg_seq.sv
module stg_seq #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req_vld,
  input  logic              req_up,
  input  logic [TIME_W-1:0] step_len,
  input  logic [TIME_W-1:0] step_space,
  input  logic [TIME_W-1:0] dir_setup,
  input  logic [TIME_W-1:0] dir_hold,
  output logic              step_act,
  output logic              dir_up,
  output logic              issue,
  output logic              issue_up
);
  logic              pend_q, pend_up_q;
  logic              pend_n, pend_up_n, dir_n;
  logic [TIME_W-1:0] act_q, space_q, hold_q, setup_q;
  logic [TIME_W-1:0] act_n, space_n, hold_n, setup_n;
  logic              busy, last, turn;

  function automatic logic [TIME_W-1:0] dec(input logic [TIME_W-1:0] v);
    return (v == '0) ? v : v - TIME_W'(1);
  endfunction

  always_comb begin
    busy  = (act_q != '0);
    last  = (act_q == TIME_W'(1));
    issue = en && pend_q && !busy && (space_q == '0) && (setup_q == '0)
            && (pend_up_q == dir_up);
    turn  = en && pend_q && !busy && (hold_q == '0) && (pend_up_q != dir_up);
    issue_up = pend_up_q;

    act_n   = issue ? ((step_len == '0) ? TIME_W'(1) : step_len) : dec(act_q);
    space_n = last ? step_space : dec(space_q);
    hold_n  = last ? dir_hold   : dec(hold_q);
    setup_n = turn ? dir_setup  : dec(setup_q);
    dir_n   = turn ? pend_up_q  : dir_up;

    pend_n    = pend_q;
    pend_up_n = pend_up_q;
    if (!en) begin
      pend_n = 1'b0;
    end else if (issue || !pend_q) begin
      // Only one request is held; extras arriving while held are dropped.
      pend_n    = req_vld;
      pend_up_n = req_vld ? req_up : pend_up_q;
    end
  end

  assign step_act = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_up_q <= 1'b0;
      dir_up    <= 1'b0;
      act_q     <= '0;
      space_q   <= '0;
      hold_q    <= '0;
      setup_q   <= '0;
    end else begin
      pend_q    <= pend_n;
      pend_up_q <= pend_up_n;
      dir_up    <= dir_n;
      act_q     <= act_n;
      space_q   <= space_n;
      hold_q    <= hold_n;
      setup_q   <= setup_n;
    end
  end
endmodule

// File: rtl/stg_pos.sv
module stg_pos #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             issue_up,
  output logic [POS_W-1:0] count
);
  logic [POS_W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (issue) count_n = issue_up ? count + POS_W'(1) : count - POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end
endmodule

// File: rtl/stg_fmt.sv
module stg_fmt
  import stg_pkg::*;
(
  input  logic [1:0] fmt,
  input  logic       step_act,
  input  logic       dir_up,
  input  logic [1:0] phase,
  output logic       out_a,
  output logic       out_b
);
  always_comb begin
    case (out_fmt_e'(fmt))
      FMT_UP_DOWN: begin
        out_a = step_act && dir_up;
        out_b = step_act && !dir_up;
      end
      FMT_QUAD: begin
        out_a = phase[1];
        out_b = phase[1] ^ phase[0];
      end
      default: begin
        out_a = step_act;
        out_b = dir_up;
      end
    endcase
  end
endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen #(
  parameter int ACC_W  = 16,
  parameter int RATE_W = 16,
  parameter int TIME_W = 8,
  parameter int POS_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [RATE_W-1:0] rate,
  input  logic [1:0]               fmt,
  input  logic [TIME_W-1:0]        step_len,
  input  logic [TIME_W-1:0]        step_space,
  input  logic [TIME_W-1:0]        dir_setup,
  input  logic [TIME_W-1:0]        dir_hold,
  output logic                     out_a,
  output logic                     out_b,
  output logic [POS_W-1:0]         pos_count,
  output logic [ACC_W-1:0]         pos_frac
);
  logic req_vld, req_up;
  logic step_act, dir_up, issue, issue_up;

  stg_accum #(.ACC_W(ACC_W), .RATE_W(RATE_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .en(en), .rate(rate),
    .req_vld(req_vld), .req_up(req_up), .frac(pos_frac)
  );

  stg_seq #(.TIME_W(TIME_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .req_vld(req_vld), .req_up(req_up),
    .step_len(step_len), .step_space(step_space),
    .dir_setup(dir_setup), .dir_hold(dir_hold),
    .step_act(step_act), .dir_up(dir_up),
    .issue(issue), .issue_up(issue_up)
  );

  stg_pos #(.POS_W(POS_W)) i_pos (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_up(issue_up),
    .count(pos_count)
  );

  stg_fmt i_fmt (
    .fmt(fmt), .step_act(step_act), .dir_up(dir_up),
    .phase(pos_count[1:0]), .out_a(out_a), .out_b(out_b)
  );
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int ACC_W = 16,
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       fmt,
  input logic             out_a,
  input logic             out_b,
  input logic [POS_W-1:0] pos_count,
  input logic [ACC_W-1:0] pos_frac,
  input logic             step_act,
  input logic             dir_up,
  input logic             issue
);
  // R10: the count moves exactly when a pulse begins
  p_count_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_count) |-> $rose(step_act));
  p_rise_moves_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_act) |-> !$stable(pos_count));
  // R4: direction never moves during or right at the end of a pulse
  p_dir_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_up) |-> (!step_act && !$past(step_act)));
  // R8: up and down lines are exclusive
  p_updown_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd1) |-> !(out_a && out_b));
  // R9: quadrature moves one bit at a time
  p_quad_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd2 && $past(fmt) == 2'd2) |->
      ($countones({out_a, out_b} ^ $past({out_a, out_b})) <= 1));
  // R7: disabled means no issue and a frozen fraction
  p_no_issue_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !issue);
  p_frac_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pos_frac));
endmodule

bind step_pulse_gen stg_checker #(.ACC_W(ACC_W), .POS_W(POS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .out_a(out_a), .out_b(out_b),
  .pos_count(pos_count), .pos_frac(pos_frac), .step_act(step_act),
  .dir_up(dir_up), .issue(issue)
);

// File: tb/test_step_pulse_gen.sv
module test_step_pulse_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic               clk = 1'b0;
  logic               rst_n, en;
  logic signed [15:0] rate;
  logic [1:0]         fmt;
  logic [7:0]         step_len, step_space, dir_setup, dir_hold;
  logic               out_a, out_b;
  logic [31:0]        pos_count;
  logic [15:0]        pos_frac;

  step_pulse_gen i_step_pulse_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .rate(rate), .fmt(fmt),
    .step_len(step_len), .step_space(step_space), .dir_setup(dir_setup),
    .dir_hold(dir_hold), .out_a(out_a), .out_b(out_b),
    .pos_count(pos_count), .pos_frac(pos_frac)
  );

  always #2.5 clk = ~clk;

  int     n_chk = 0, n_fail = 0, cyc = 0;
  bit     done = 0;
  longint total;

  // monitor state
  bit  mon_on = 0;
  bit  prev_act, prev_b, prev_a;
  int  prev_cnt, hi_len, lo_len, since_fall, since_dir;
  bit  lo_seen, fall_seen, dir_seen;
  int  up_rises, dn_rises;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint t);
    return (t >= 0) ? t / 65536 : -((-t + 65535) / 65536);
  endfunction

  function automatic logic [1:0] gray2(input logic [1:0] p);
    case (p)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic mon_clear();
    prev_act = 0; prev_a = 0; prev_b = out_b; prev_cnt = $signed(pos_count);
    hi_len = 0; lo_len = 0; since_fall = 0; since_dir = 0;
    lo_seen = 0; fall_seen = 0; dir_seen = 0; up_rises = 0; dn_rises = 0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      automatic int  cnt = $signed(pos_count);
      automatic bit  act = (fmt == 2'd1) ? (out_a | out_b) : out_a;
      automatic bit  rise = act && !prev_act;
      automatic bit  fall = !act && prev_act;
      automatic bit  dchg = (fmt == 2'd0) && (out_b != prev_b);
      if (fmt == 2'd2) begin
        chk({out_a, out_b} == gray2(pos_count[1:0]), "R9 gray", {out_a, out_b}, gray2(pos_count[1:0]));
        chk($countones({out_a, out_b} ^ {prev_a, prev_b}) <= 1, "R9 one-bit", {out_a, out_b}, {prev_a, prev_b});
        chk((cnt - prev_cnt <= 1) && (cnt - prev_cnt >= -1), "R10 step size", cnt, prev_cnt);
      end else begin
        if (rise) begin
          automatic int d = (fmt == 2'd0) ? (out_b ? 1 : -1) : (out_a ? 1 : -1);
          chk(cnt == prev_cnt + d, "R10 count at rise", cnt, prev_cnt + d);
          if (lo_seen) chk(lo_len >= atleast1(step_space), "R3 gap", lo_len, atleast1(step_space));
          if (fmt == 2'd0 && dir_seen)
            chk(since_dir >= atleast1(dir_setup), "R5 setup", since_dir, atleast1(dir_setup));
          if (fmt == 2'd1) begin
            chk(!(out_a && out_b), "R8 exclusive", {out_a, out_b}, 0);
            if (out_a) up_rises++; else dn_rises++;
          end
        end else begin
          chk(cnt == prev_cnt, "R10 count steady", cnt, prev_cnt);
        end
        if (fall) chk(hi_len == atleast1(step_len), "R2 width", hi_len, atleast1(step_len));
        if (dchg) begin
          chk(!act && !prev_act, "R4 dir quiet", act, 0);
          if (fall_seen) chk(since_fall >= atleast1(dir_hold), "R4 hold", since_fall, atleast1(dir_hold));
        end
        // updates
        if (rise) hi_len = 1; else if (act) hi_len++;
        if (fall) begin lo_len = 1; lo_seen = 1; since_fall = 1; fall_seen = 1; end
        else if (!act) begin lo_len++; since_fall++; end
        if (dchg) begin since_dir = 1; dir_seen = 1; end else since_dir++;
      end
      prev_act = act; prev_a = out_a; prev_b = out_b; prev_cnt = cnt;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; rate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    total = 0;
    @(negedge clk);
    // R11 reset state
    chk(pos_count == 0, "R11 count", $signed(pos_count), 0);
    chk(pos_frac == 0, "R11 frac", pos_frac, 0);
    chk(out_a == 0 && out_b == 0, "R11 outputs", {out_a, out_b}, 0);
  endtask

  task automatic end_checks(input string tag);
    chk($signed(pos_count) == fdiv(total), {"R1 R6 count ", tag}, $signed(pos_count), fdiv(total));
    chk(pos_frac == 16'(total - fdiv(total) * 65536), {"R1 frac ", tag}, pos_frac, total - fdiv(total) * 65536);
  endtask

  task automatic run_vec(input int f, input int t, input int r);
    int tl[4] = '{1, 3, 2, 4};
    int ts[4] = '{0, 2, 5, 1};
    int tu[4] = '{0, 3, 1, 4};
    int th[4] = '{0, 2, 4, 1};
    int r1[4] = '{3000, 4096, -1234, 777};
    int r2[4] = '{-2500, 4096, 4000, -4096};
    fmt = 2'(f);
    step_len = 8'(tl[t]); step_space = 8'(ts[t]);
    dir_setup = 8'(tu[t]); dir_hold = 8'(th[t]);
    do_reset();
    mon_clear();
    mon_on = 1;
    en = 1'b1; rate = 16'(r1[r]);
    repeat (300) @(negedge clk);
    total += longint'(r1[r]) * 300;
    rate = 16'(r2[r]);
    repeat (300) @(negedge clk);
    total += longint'(r2[r]) * 300;
    rate = '0;
    repeat (60) @(negedge clk);
    mon_on = 0;
    end_checks("sweep");
    if (f == 1)
      chk(up_rises - dn_rises == $signed(pos_count), "R8 up-down net", up_rises - dn_rises, $signed(pos_count));
  endtask

  initial begin
    fmt = 2'd0; step_len = 8'd1; step_space = 8'd0; dir_setup = 8'd0; dir_hold = 8'd0;
    for (int f = 0; f < 3; f++)
      for (int t = 0; t < 4; t++)
        for (int r = 0; r < 4; r++)
          run_vec(f, t, r);

    // R6: long pulses, requests every 4 clocks; one issued, one held, rest dropped
    fmt = 2'd0; step_len = 8'd40; step_space = 8'd0; dir_setup = 8'd0; dir_hold = 8'd0;
    do_reset();
    en = 1'b1; rate = 16'sd16384;
    repeat (40) @(negedge clk);
    rate = '0;
    repeat (120) @(negedge clk);
    chk($signed(pos_count) == 2, "R6 held one", $signed(pos_count), 2);
    chk(pos_frac == 0, "R1 frac after R6 run", pos_frac, 0);

    // R7: disable freezes everything
    step_len = 8'd10;
    do_reset();
    en = 1'b1; rate = 16'sd8192;
    repeat (100) @(negedge clk);
    en = 1'b0;
    begin
      automatic int c0 = $signed(pos_count);
      automatic int f0 = pos_frac;
      repeat (12) @(negedge clk);
      chk(out_a == 0, "R7 pulse finished", out_a, 0);
      repeat (60) @(negedge clk);
      chk($signed(pos_count) == c0, "R7 count frozen", $signed(pos_count), c0);
      chk(pos_frac == 16'(f0), "R7 frac frozen", pos_frac, f0);
      chk(out_a == 0, "R7 no pulses", out_a, 0);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule